// File: doc/BRIEF.md
# Button Matrix Select Reader

This block holds the key-input register of a small controller. Eight buttons are split into a lower group (key bits 3:0) and an upper group (key bits 7:4). Software writes a two-bit group select into the register and then reads back a byte whose low nibble shows the chosen buttons. A pressed button reads as 0 and a released one reads as 1.

The raw key vector (1 = pressed) passes through a two-flop synchronizer before use. A read strobe captures the composed byte into the read-data register. An interrupt request pulses for one cycle whenever any bit of the composed low nibble falls from 1 to 0. That happens when a key in the visible group is pressed, and also when a select change makes a held key visible.

Top module: `keypad_select_reader`

## Requirements
- R1: After reset the select field is 2'b11, the read-data output is 8'hFF and the interrupt request is low.
- R2: A write stores only bits 5:4 of the write data as the select field. All other write-data bits have no effect on any later read.
- R3: With select 2'b11 the low nibble reads 4'hF whatever keys are pressed.
- R4: With select 2'b10 the low nibble is the inverse of key bits 7:4.
- R5: With select 2'b01 the low nibble is the inverse of key bits 3:0.
- R6: With select 2'b00 the low nibble is the inverse of (key bits 7:4 OR key bits 3:0).
- R7: A read strobe high at a rising edge loads the read-data output with bits 7:6 = 2'b11, bits 5:4 = select, and bits 3:0 = low nibble. The output appears after that edge and holds until the next read strobe.
- R8: A key change applied before rising edge e1 is not seen by a read captured at edge e1+1. It is seen by a read captured at edge e1+2.
- R9: The interrupt request goes high for the cycle that follows the edge at which the composed low nibble is sampled with a bit that fell from 1 to 0. A bit rising from 0 to 1, or an unchanged nibble, raises no request.
- R10: When a write and a read strobe share an edge, the read captures the select value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| keys_i | input | 8 | Raw pressed-key vector, 1 = pressed |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Captured read byte |
| irq_o | output | 1 | One-cycle key-press interrupt request |

## Verification
Several properties are checked on every cycle. The select field loads or holds according to the write strobe, and the synchronizer's last stage follows its previous stage. The read byte keeps its fixed ones and its select field, and holds between reads. A blank select gives an all-ones nibble, a nibble fall always raises the request, and a steady nibble never does. Some behaviours can only be shown by the bench scenarios: the exact group mapping under each select code, the two-edge key latency, the write-and-read collision ordering, and the absence of an interrupt when keys are released.

// File: rtl/kp_pkg.sv
package kp_pkg;
  localparam int SEL_W = 2;

  typedef enum logic [SEL_W-1:0] {
    GRP_BOTH = 2'b00,
    GRP_LOW  = 2'b01,
    GRP_HIGH = 2'b10,
    GRP_NONE = 2'b11
  } grp_sel_e;
endpackage

// File: rtl/kp_sync.sv
module kp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign sync_o = stg[STAGES-1];

  generate
    if (STAGES >= 2) begin : g_chk
      // R8: the output stage follows the stage before it by one edge
      a_r8_stage_follow: assert property (@(posedge clk) disable iff (!rst_n)
        stg[STAGES-1] == $past(stg[STAGES-2]));
    end
  endgenerate
endmodule

// File: rtl/kp_select_reg.sv
module kp_select_reg #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] wsel_i,
  output logic [SEL_W-1:0] sel_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sel_o <= '1;
    else if (wr_i) sel_o <= wsel_i;
  end

  // R2: a write loads the select field
  a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> sel_o == $past(wsel_i));
  // R2: without a write the select field keeps its value
  a_r2_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(sel_o));
endmodule

// File: rtl/kp_compose.sv
module kp_compose
  import kp_pkg::*;
#(
  parameter int KEY_W   = 8,
  parameter int REG_W   = 8,
  parameter int SEL_LSB = 4
) (
  input  logic [KEY_W-1:0]   keys_i,
  input  logic [SEL_W-1:0]   sel_i,
  output logic [KEY_W/2-1:0] nib_o,
  output logic [REG_W-1:0]   byte_o
);
  localparam int GROUP_W = KEY_W / 2;

  function automatic logic [GROUP_W-1:0] pick_group(
    input logic [KEY_W-1:0] k,
    input grp_sel_e         g
  );
    logic [GROUP_W-1:0] lo, hi, vis;
    lo = k[GROUP_W-1:0];
    hi = k[KEY_W-1:GROUP_W];
    case (g)
      GRP_BOTH: vis = lo | hi;
      GRP_LOW:  vis = lo;
      GRP_HIGH: vis = hi;
      default:  vis = '0;
    endcase
    return ~vis;
  endfunction

  function automatic logic [REG_W-1:0] pack_byte(
    input logic [SEL_W-1:0]   s,
    input logic [GROUP_W-1:0] n
  );
    logic [REG_W-1:0] b;
    b = '1;
    b[SEL_LSB +: SEL_W] = s;
    b[GROUP_W-1:0]      = n;
    return b;
  endfunction

  assign nib_o  = pick_group(keys_i, grp_sel_e'(sel_i));
  assign byte_o = pack_byte(sel_i, nib_o);
endmodule

// File: rtl/kp_press_irq.sv
module kp_press_irq #(
  parameter int GW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [GW-1:0] nib_i,
  output logic          fall_evt_o,
  output logic          irq_o
);
  logic [GW-1:0] nib_prev;

  assign fall_evt_o = |(nib_prev & ~nib_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nib_prev <= '1;
      irq_o    <= 1'b0;
    end else begin
      nib_prev <= nib_i;
      irq_o    <= fall_evt_o;
    end
  end

  // R9: a nibble bit falling between two samples raises the request
  a_r9_fall_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(nib_i) & ~nib_i)) |=> irq_o);
  // R9: an unchanged nibble never raises the request
  a_r9_steady_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(nib_i) |=> !irq_o);
endmodule

// File: rtl/keypad_select_reader.sv
module keypad_select_reader
  import kp_pkg::*;
#(
  parameter int KEY_W       = 8,
  parameter int REG_W       = 8,
  parameter int SEL_LSB     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] keys_i,
  input  logic             reg_wr_i,
  input  logic             reg_rd_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  output logic             irq_o
);
  localparam int GROUP_W = KEY_W / 2;
  localparam int FILL_LSB = SEL_LSB + SEL_W;

  logic [KEY_W-1:0]   keys_sync;
  logic [SEL_W-1:0]   sel_q;
  logic [GROUP_W-1:0] nib_now;
  logic [REG_W-1:0]   byte_now;
  logic               fall_evt;
  logic               wdata_unused;

  assign wdata_unused = ^reg_wdata_i;

  kp_sync #(.W(KEY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(keys_i), .sync_o(keys_sync)
  );

  kp_select_reg #(.SEL_W(SEL_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .wr_i(reg_wr_i),
    .wsel_i(reg_wdata_i[SEL_LSB +: SEL_W]), .sel_o(sel_q)
  );

  kp_compose #(.KEY_W(KEY_W), .REG_W(REG_W), .SEL_LSB(SEL_LSB)) u_comp (
    .keys_i(keys_sync), .sel_i(sel_q), .nib_o(nib_now), .byte_o(byte_now)
  );

  kp_press_irq #(.GW(GROUP_W)) u_irq (
    .clk(clk), .rst_n(rst_n), .nib_i(nib_now),
    .fall_evt_o(fall_evt), .irq_o(irq_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        reg_rdata_o <= '1;
    else if (reg_rd_i) reg_rdata_o <= byte_now;
  end

  // R3: a blank select shows no pressed key
  a_r3_blank_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == GRP_NONE) |-> (&nib_now));
  // R7: the fixed upper bits always read as ones
  a_r7_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
    &reg_rdata_o[REG_W-1:FILL_LSB]);
  // R7 and R10: a read captures the select held before the edge
  a_r7_sel_field: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_i |=> reg_rdata_o[SEL_LSB +: SEL_W] == $past(sel_q));
  // R7: without a read strobe the output holds
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> $stable(reg_rdata_o));
  // R9: the request is registered from the fall event
  a_r9_evt_to_irq: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> irq_o);
endmodule

// File: tb/tb_keypad_select_reader.sv
module tb_keypad_select_reader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] keys = 8'h00;
  logic       wr = 1'b0;
  logic       rd = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  keypad_select_reader dut (
    .clk(clk), .rst_n(rst_n), .keys_i(keys), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  // Behavioural reference model
  logic [7:0] sq[$];
  logic [1:0] m_sel;
  logic [3:0] m_prev;
  logic       m_irq;
  logic [7:0] m_rdata;

  function automatic logic [3:0] ref_nib(input logic [7:0] k, input logic [1:0] s);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      bit pressed;
      if (s == 2'd0)      pressed = k[i] || k[i+4];
      else if (s == 2'd1) pressed = k[i];
      else if (s == 2'd2) pressed = k[i+4];
      else                pressed = 1'b0;
      r[i] = !pressed;
    end
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq = {8'h00, 8'h00};
      m_sel = 2'b11; m_prev = 4'hF; m_irq = 1'b0; m_rdata = 8'hFF;
    end else begin
      logic [3:0] n;
      n = ref_nib(sq[0], m_sel);
      m_irq = (m_prev & ~n) != 4'h0;
      m_prev = n;
      if (rd) m_rdata = {2'b11, m_sel, n};
      if (wr) m_sel = wdata[5:4];
      void'(sq.pop_front());
      sq.push_back(keys);
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R7 model rdata", rdata, m_rdata);
      check("R9 model irq", {7'd0, irq}, {7'd0, m_irq});
    end
  end

  task automatic do_write(input logic [7:0] v);
    @(negedge clk); wr = 1'b1; wdata = v;
    @(negedge clk); wr = 1'b0; wdata = 8'h00;
  endtask

  task automatic do_read(output logic [7:0] v);
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0; v = rdata;
  endtask

  task automatic set_keys(input logic [7:0] k);
    @(negedge clk); keys = k;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [7:0] v, va, vb;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset rdata", rdata, 8'hFF);
    check("R1 reset irq", {7'd0, irq}, 8'h00);
    do_read(v);
    check("R1 reset select blank", v, 8'hFF);

    // R5: low group
    do_write(8'h10);
    set_keys(8'h05);
    do_read(v);
    check("R5 low group", v, 8'hDA);

    // R4: high group
    do_write(8'h20);
    set_keys(8'h30);
    do_read(v);
    check("R4 high group", v, 8'hEC);

    // R6: both groups merged
    do_write(8'h00);
    set_keys(8'h21);
    do_read(v);
    check("R6 merged groups", v, 8'hCC);

    // R3: no group
    do_write(8'h30);
    set_keys(8'hFF);
    do_read(v);
    check("R3 no group", v, 8'hFF);

    // R2: only bits 5:4 stored
    do_write(8'hDA);
    set_keys(8'h00);
    do_read(v);
    check("R2 only select bits kept", v, 8'hDF);

    // R7: output holds without a read
    set_keys(8'h0F);
    check("R7 hold between reads", rdata, 8'hDF);
    set_keys(8'h00);

    // R8: two-edge synchronizer latency
    @(negedge clk); keys = 8'h01; rd = 1'b0;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); va = rdata;
    @(negedge clk); vb = rdata; rd = 1'b0;
    check("R8 old value one edge late", va, 8'hDF);
    check("R8 new value two edges late", vb, 8'hDE);
    set_keys(8'h00);

    // R9: press pulse timing
    @(negedge clk); keys = 8'h02;
    @(negedge clk); check("R9 no irq after e1", {7'd0, irq}, 8'h00);
    @(negedge clk); check("R9 no irq after e2", {7'd0, irq}, 8'h00);
    @(negedge clk); check("R9 irq after e3", {7'd0, irq}, 8'h01);
    @(negedge clk); check("R9 single pulse", {7'd0, irq}, 8'h00);
    @(negedge clk); keys = 8'h00;
    cnt = 0;
    repeat (6) begin @(negedge clk); if (irq) cnt++; end
    check("R9 release no irq", cnt[7:0], 8'h00);

    // R9: select change exposing a held key
    do_write(8'h30);
    set_keys(8'h01);
    cnt = 0;
    do_write(8'h10);
    repeat (4) begin @(negedge clk); if (irq) cnt++; end
    check("R9 select exposes key", cnt[7:0], 8'h01);
    set_keys(8'h00);

    // R10: write and read on the same edge
    @(negedge clk); wr = 1'b1; wdata = 8'h20; rd = 1'b1;
    @(negedge clk); wr = 1'b0; rd = 1'b0; v = rdata;
    check("R10 read sees old select", v, 8'hDF);
    do_read(v);
    check("R10 later read sees new select", v, 8'hEF);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule